// File: doc/BRIEF.md
# Stalled-Rotor Protection Latch

This block supervises a brushless motor drive while it is commanded to run. A slow time base (one-cycle tick pulses) advances two supervision counters. The first measures how long the speed loop has reported "not locked". The second measures how long it has been since the last edge of the reference clock. If either window reaches its programmed terminal count, a shutoff flag is latched and the commutation logic turns off the low-side drive. The flag survives everything except a stop command or a full reset. The stall window is held cleared while a commanded deceleration is in progress, so a change of reference frequency cannot trip it. Reference-clock loss is still watched during deceleration.

The same time base also produces the power-on initialisation pulse. After reset, the init output stays high until a fixed number of ticks has been seen. If the time base never runs, the downstream logic therefore stays in reset. While init is high, both windows are cleared and no shutoff can latch. A guard-enable input removes both trip sources from the latch and leaves the init pulse unchanged.

Top module: `stall_guard`

## Requirements
- R1: While rst_n is low, drive_off_o is 0 and init_rst_o is 1.
- R2: init_rst_o falls in the cycle after the POR_TICKS-th tick seen since reset (default 4). Without ticks it stays 1, and once 0 it stays 0 until the next reset.
- R3: With run_i=1, locked_i=0, decel_i=0, guard_en_i=1 and init low, drive_off_o rises in the cycle after the stall_limit_i-th consecutive tick. A limit of 0 behaves as 1.
- R4: A cycle with locked_i=1 clears the stall window, so a full stall_limit_i further unlocked ticks are needed to trip.
- R5: While decel_i=1 the stall window is held at zero and cannot trip. Counting restarts from zero when decel_i returns to 0.
- R6: Once drive_off_o is 1 it stays 1 while run_i stays 1, whatever locked_i, decel_i or tick_i do.
- R7: run_i=0 clears drive_off_o in the next cycle and clears both windows.
- R8: While running, drive_off_o rises in the cycle after loss_limit_i consecutive ticks with no ref_edge_i. Any ref_edge_i cycle clears that window.
- R9: With guard_en_i=0, neither window sets drive_off_o. The init pulse behaves as in R2.
- R10: While init_rst_o is 1, ticks do not advance either window and drive_off_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 = run commanded, 0 = stop |
| locked_i | input | 1 | Speed loop reports lock |
| decel_i | input | 1 | Commanded deceleration in progress |
| tick_i | input | 1 | One-cycle time-base pulse |
| ref_edge_i | input | 1 | One-cycle pulse per reference clock edge |
| guard_en_i | input | 1 | 1 = shutoff protection active |
| stall_limit_i | input | STALL_W | Stall window terminal count in ticks |
| loss_limit_i | input | LOSS_W | Reference-loss window terminal count in ticks |
| drive_off_o | output | 1 | Latched low-side drive shutoff |
| init_rst_o | output | 1 | Power-on initialisation pulse |

## Verification
A window counter that fails to clear on lock, on deceleration or on a reference edge shows up as drive_off_o rising early, within one tick of the expected count. A counter that fails to advance shows up as drive_off_o missing its rise. A latch that fails to hold or to clear is visible at drive_off_o one cycle after the lock or stop input changes. A bad init counter moves the falling edge of init_rst_o away from the POR_TICKS-th tick, and this is checked to the exact cycle.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int DEF_STALL_W   = 16;
  localparam int DEF_LOSS_W    = 12;
  localparam int DEF_POR_TICKS = 4;
endpackage

// File: rtl/sg_window_cnt.sv
module sg_window_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         hit
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   cnt_plus;

  assign cnt_plus = {1'b0, cnt_q} + (W+1)'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (inc && (cnt_q != CNT_MAX))
      cnt_d = cnt_q + W'(1);
  end

  assign hit = inc && !clr && (cnt_plus >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sg_por_pulse.sv
module sg_por_pulse #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic init_rst
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          init_q, init_d;
  logic          adv;

  assign adv = init_q && tick;

  always_comb begin
    cnt_d  = cnt_q;
    init_d = init_q;
    if (adv) begin
      if (cnt_q == LAST)
        init_d = 1'b0;
      else
        cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      init_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      init_q <= init_d;
    end
  end

  assign init_rst = init_q;
endmodule

// File: rtl/sg_trip_latch.sv
module sg_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic q
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (clr)
      q_d = 1'b0;
    else if (set)
      q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_q <= 1'b0;
    else
      q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/stall_guard.sv
module stall_guard #(
  parameter int STALL_W   = sg_pkg::DEF_STALL_W,
  parameter int LOSS_W    = sg_pkg::DEF_LOSS_W,
  parameter int POR_TICKS = sg_pkg::DEF_POR_TICKS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               locked_i,
  input  logic               decel_i,
  input  logic               tick_i,
  input  logic               ref_edge_i,
  input  logic               guard_en_i,
  input  logic [STALL_W-1:0] stall_limit_i,
  input  logic [LOSS_W-1:0]  loss_limit_i,
  output logic               drive_off_o,
  output logic               init_rst_o
);
  logic init_rst;
  logic stall_clr, loss_clr;
  logic stall_hit, loss_hit;
  logic trip_set, latch_clr;

  sg_por_pulse #(.TICKS(POR_TICKS)) u_por (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .init_rst (init_rst)
  );

  // stall window: cleared unless running, unlocked and not decelerating
  assign stall_clr = init_rst || !run_i || locked_i || decel_i;

  sg_window_cnt #(.W(STALL_W)) u_stall_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stall_clr),
    .inc   (tick_i),
    .limit (stall_limit_i),
    .hit   (stall_hit)
  );

  // reference-loss window: cleared by each reference edge
  assign loss_clr = init_rst || !run_i || ref_edge_i;

  sg_window_cnt #(.W(LOSS_W)) u_loss_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (loss_clr),
    .inc   (tick_i),
    .limit (loss_limit_i),
    .hit   (loss_hit)
  );

  assign trip_set  = guard_en_i && (stall_hit || loss_hit);
  assign latch_clr = init_rst || !run_i;

  sg_trip_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (latch_clr),
    .set   (trip_set),
    .q     (drive_off_o)
  );

  assign init_rst_o = init_rst;
endmodule

// File: rtl/sg_checker.sv
module sg_checker (
  input logic clk,
  input logic rst_n,
  input logic run_i,
  input logic decel_i,
  input logic ref_edge_i,
  input logic guard_en_i,
  input logic drive_off_o,
  input logic init_rst_o
);
  // R6: latched shutoff holds while running
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_off_o && run_i) |=> drive_off_o);

  // R7: stop clears the shutoff
  p_stop_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !drive_off_o);

  // R2: init pulse never comes back after falling
  p_init_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_rst_o |=> !init_rst_o);

  // R10: no shutoff while init is active
  p_init_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_rst_o |-> !drive_off_o);

  // R9: a rise of the shutoff needs protection enabled
  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_off_o) |-> $past(guard_en_i));

  // R5: deceleration with a live reference cannot trip
  p_decel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && decel_i && ref_edge_i && !drive_off_o) |=> !drive_off_o);
endmodule

bind stall_guard sg_checker u_sg_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_i       (run_i),
  .decel_i     (decel_i),
  .ref_edge_i  (ref_edge_i),
  .guard_en_i  (guard_en_i),
  .drive_off_o (drive_off_o),
  .init_rst_o  (init_rst_o)
);

// File: tb/stall_guard_tb_top.sv
module stall_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, run, locked, decel, tick, ref_edge, en;
  logic [15:0] stall_lim;
  logic [11:0] loss_lim;
  logic        drive_off, init_rst;

  int  checks = 0;
  int  errors = 0;
  bit  e_init;
  bit  q_off[$];
  bit  q_init[$];
  string q_tag[$];

  always #2 clk = ~clk;

  stall_guard dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run), .locked_i(locked),
    .decel_i(decel), .tick_i(tick), .ref_edge_i(ref_edge),
    .guard_en_i(en), .stall_limit_i(stall_lim), .loss_limit_i(loss_lim),
    .drive_off_o(drive_off), .init_rst_o(init_rst)
  );

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver: starts at a negedge, applies one cycle, queues the expectation
  task automatic cyc(input bit t, input bit r, input bit eo, input string tag);
    tick = t; ref_edge = r;
    q_off.push_back(eo); q_init.push_back(e_init); q_tag.push_back(tag);
    @(negedge clk);
    tick = 1'b0; ref_edge = 1'b0;
  endtask

  task automatic run_ticks(input int n, input bit r, input bit eo, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, r, eo, tag);
  endtask

  // monitor: compares right after the edge that produced the result
  always @(posedge clk) begin
    #1;
    if (q_off.size() > 0) begin
      bit eo, ei; string tg;
      eo = q_off.pop_front(); ei = q_init.pop_front(); tg = q_tag.pop_front();
      checks++;
      if (drive_off !== eo || init_rst !== ei) begin
        errors++;
        $display("FAIL %s: off=%b init=%b expected off=%b init=%b",
                 tg, drive_off, init_rst, eo, ei);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; run = 1; locked = 0; decel = 0; tick = 0; ref_edge = 0;
    en = 1; stall_lim = 16'd5; loss_lim = 12'd8; e_init = 1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (drive_off !== 1'b0 || init_rst !== 1'b1) begin
      errors++;
      $display("FAIL R1: off=%b init=%b expected off=0 init=1", drive_off, init_rst);
    end
    @(negedge clk); rst_n = 1;
    // R10 / R2: running and unlocked during init, nothing counts
    cyc(1, 1, 0, "R10"); cyc(0, 0, 0, "R10"); cyc(1, 1, 0, "R10"); cyc(1, 1, 0, "R2");
    e_init = 0;
    cyc(1, 1, 0, "R2");
    // R3: trip on the 5th unlocked tick
    run_ticks(4, 1, 0, "R3"); cyc(1, 1, 1, "R3");
    // R6: holds after lock returns
    locked = 1; run_ticks(3, 1, 1, "R6"); decel = 1; cyc(1, 1, 1, "R6"); decel = 0;
    // R7: stop clears latch and window
    run = 0; cyc(0, 0, 0, "R7"); run = 1; locked = 0;
    run_ticks(4, 1, 0, "R7");
    // R4: a lock cycle restarts the window
    locked = 1; cyc(1, 1, 0, "R4"); locked = 0;
    run_ticks(4, 1, 0, "R4"); cyc(1, 1, 1, "R4");
    run = 0; cyc(0, 0, 0, "R7"); run = 1;
    // R5: deceleration blocks stall counting
    decel = 1; run_ticks(10, 1, 0, "R5"); decel = 0;
    run_ticks(4, 1, 0, "R5"); cyc(1, 1, 1, "R5");
    run = 0; cyc(0, 0, 0, "R7"); run = 1;
    // R8: reference loss after 8 ticks without an edge
    locked = 1;
    run_ticks(7, 0, 0, "R8"); cyc(1, 0, 1, "R8");
    run = 0; cyc(0, 0, 0, "R7"); run = 1;
    run_ticks(7, 0, 0, "R8"); cyc(0, 1, 0, "R8");
    run_ticks(7, 0, 0, "R8"); cyc(1, 0, 1, "R8");
    run = 0; cyc(0, 0, 0, "R7"); run = 1;
    // R3: limit 0 behaves as 1
    stall_lim = 16'd0; locked = 0;
    cyc(0, 1, 0, "R3"); cyc(1, 1, 1, "R3");
    run = 0; cyc(0, 0, 0, "R7"); run = 1; stall_lim = 16'd5;
    // R9: protection disabled, both windows exceeded
    en = 0;
    run_ticks(20, 0, 0, "R9");
    run = 0; cyc(0, 0, 0, "R9"); run = 1;
    // R9 / R2: init pulse unaffected by disable, held without ticks
    e_init = 1; rst_n = 0; cyc(0, 0, 0, "R1"); rst_n = 1;
    for (int i = 0; i < 30; i++) cyc(0, 0, 0, "R2");
    run_ticks(3, 0, 0, "R9");
    e_init = 0; cyc(1, 0, 0, "R9");
    cyc(0, 0, 0, "R2");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule